// File: doc/BRIEF.md
# Receive drop event counters

The block counts receive frames that were lost on their way to the host. It keeps two counters. The first counts frames dropped because no receive buffer descriptor was free when the frame arrived. The second counts frames lost because the receive FIFO was full. Each source that detects a drop raises its event input for exactly one clock cycle per lost frame.

The two counts and their overflow flags are packed into one 32-bit status word, which software reads. The counters have different widths: the no-descriptor count is 16 bits and the FIFO count is 11 bits. A counter that reaches its all-ones value stays there. The next event then sets that counter's overflow flag, and software reads a set flag as "at least the full range was lost".

Reading is destructive. The read strobe samples the word in the cycle it is high, and both counters and both flags are then cleared. An event that arrives in the read cycle is not lost: it becomes a count of one after the clear.

Top module: `rx_drop_counters`

## Requirements
- R1: After reset, `status_o` is 0x00000000.
- R2: Each cycle with `miss_evt_i` high adds one to the no-descriptor count in `status_o[15:0]`. In a cycle with no event and no read, the word does not change.
- R3: Each cycle with `fifo_evt_i` high adds one to the FIFO count in `status_o[27:17]`.
- R4: Once the no-descriptor count is 0xFFFF it stays at 0xFFFF. The next event sets `status_o[16]`, and that flag stays set until a read.
- R5: Once the FIFO count is 0x7FF it stays at 0x7FF. The next event sets `status_o[28]`, and that flag stays set until a read.
- R6: While `rd_i` is high, `status_o` shows the value accumulated so far. In the next cycle, both counts and both flags are zero.
- R7: An event of either kind in a cycle with `rd_i` high gives a count of 1 in its field after the clear.
- R8: Events of both kinds in the same cycle are both counted.
- R9: Bits 31:29 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_evt_i | input | 1 | One-cycle pulse: a frame was dropped because no descriptor was free |
| fifo_evt_i | input | 1 | One-cycle pulse: a frame was lost to receive FIFO overflow |
| rd_i | input | 1 | Read strobe; clears the counters and flags after this cycle |
| status_o | output | 32 | Packed word: counts and overflow flags |

## Verification
A vector walk drives each event kind alone, then both kinds together, then idle cycles, then reads with and without coincident events. This separates a missing increment, a swapped field, a lost simultaneous event and an event dropped by the clear. Long runs of events push each counter to its all-ones value and one step beyond, then further still. These runs show whether the counter wraps, whether the flag is set one event late or early, and whether the two counters use their own widths. The word is also sampled while the read strobe is high, to show that the pre-clear value is returned and that both flags clear together.

// File: rtl/rx_drop_pkg.sv
package rx_drop_pkg;
  localparam int WORD_W      = 32;
  localparam int MISS_W_DEF  = 16;
  localparam int FIFO_W_DEF  = 11;
endpackage

// File: rtl/drop_sat_counter.sv
module drop_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c,
                                            input logic e, input logic clr);
    if (clr) return {{(W-1){1'b0}}, e};
    if (e && (c != CNT_MAX)) return c + 1'b1;
    return c;
  endfunction

  function automatic logic next_ovf(input logic f, input logic [W-1:0] c,
                                    input logic e, input logic clr);
    if (clr) return 1'b0;
    return f | (e && (c == CNT_MAX));
  endfunction

  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         sat_evt;   // event that arrives while already saturated
  logic         step_evt;  // event that moves the count

  assign at_max_o = (cnt_q == CNT_MAX);
  assign sat_evt  = evt_i && at_max_o && !clr_i;
  assign step_evt = evt_i && !at_max_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= next_cnt(cnt_q, evt_i, clr_i);
      ovf_q <= next_ovf(ovf_q, cnt_q, evt_i, clr_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R2/R3: an unsaturated event moves the count by one
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_evt |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R4/R5: saturated count holds, flag rises
  p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max_o && !clr_i) |=> at_max_o);
  p_ovf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_evt |=> ovf_o);
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  // R6/R7: clear leaves only the coincident event
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ovf_o && (cnt_o == {{(W-1){1'b0}}, $past(evt_i)})));
  // flag only rises on a saturated event
  p_ovf_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(sat_evt));
endmodule

// File: rtl/drop_word_pack.sv
module drop_word_pack #(
  parameter int WORD_W = 32,
  parameter int A_W    = 16,
  parameter int B_W    = 11
) (
  input  logic [A_W-1:0]    a_cnt_i,
  input  logic              a_ovf_i,
  input  logic [B_W-1:0]    b_cnt_i,
  input  logic              b_ovf_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int A_OVF = A_W;
  localparam int B_LSB = A_W + 1;
  localparam int B_OVF = B_LSB + B_W;

  always_comb begin
    word_o = '0;
    word_o[A_W-1:0]         = a_cnt_i;
    word_o[A_OVF]           = a_ovf_i;
    word_o[B_LSB +: B_W]    = b_cnt_i;
    word_o[B_OVF]           = b_ovf_i;
  end
endmodule

// File: rtl/rx_drop_counters.sv
module rx_drop_counters
  import rx_drop_pkg::*;
#(
  parameter int MISS_W = MISS_W_DEF,
  parameter int FIFO_W = FIFO_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_evt_i,
  input  logic              fifo_evt_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] status_o
);
  localparam int FIFO_LSB = MISS_W + 1;

  logic [MISS_W-1:0] miss_cnt;
  logic [FIFO_W-1:0] fifo_cnt;
  logic              miss_ovf, fifo_ovf;
  logic              miss_max, fifo_max;
  logic              both_step; // both counters advance this cycle

  drop_sat_counter #(.W(MISS_W)) u_miss (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(miss_evt_i), .clr_i(rd_i),
    .cnt_o(miss_cnt), .ovf_o(miss_ovf), .at_max_o(miss_max));

  drop_sat_counter #(.W(FIFO_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(fifo_evt_i), .clr_i(rd_i),
    .cnt_o(fifo_cnt), .ovf_o(fifo_ovf), .at_max_o(fifo_max));

  drop_word_pack #(.WORD_W(WORD_W), .A_W(MISS_W), .B_W(FIFO_W)) u_pack (
    .a_cnt_i(miss_cnt), .a_ovf_i(miss_ovf),
    .b_cnt_i(fifo_cnt), .b_ovf_i(fifo_ovf),
    .word_o(status_o));

  assign both_step = miss_evt_i && fifo_evt_i && !rd_i && !miss_max && !fifo_max;

  // R8: simultaneous events advance both fields of the word
  p_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_step |=> ((status_o[MISS_W-1:0] == $past(status_o[MISS_W-1:0]) + 1'b1) &&
                   (status_o[FIFO_LSB +: FIFO_W] == $past(status_o[FIFO_LSB +: FIFO_W]) + 1'b1)));
  // R2: quiet cycle keeps the word
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_evt_i && !fifo_evt_i && !rd_i) |=> $stable(status_o));
endmodule

// File: tb/rx_drop_counters_test.sv
module rx_drop_counters_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m = 1'b0, f = 1'b0, r = 1'b0;
  logic [31:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_drop_counters uut (.clk_i(clk), .rst_ni(rst_n), .miss_evt_i(m),
                        .fifo_evt_i(f), .rd_i(r), .status_o(st));

  function automatic logic [31:0] pack(int mc, bit mo, int fc, bit fo);
    return (32'(mc) & 32'hFFFF) | (32'(mo) << 16) | ((32'(fc) & 32'h7FF) << 17) | (32'(fo) << 28);
  endfunction

  task automatic chk(string tag, logic [31:0] exp);
    checks++;
    if (st !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, st, exp);
    end
  endtask

  // {miss, fifo, read, expected word after the edge}
  localparam logic [34:0] VEC [9] = '{
    {3'b100, 32'h0000_0001},  // R2
    {3'b100, 32'h0000_0002},  // R2
    {3'b010, 32'h0002_0002},  // R3
    {3'b110, 32'h0004_0003},  // R8
    {3'b000, 32'h0004_0003},  // R2 idle
    {3'b001, 32'h0000_0000},  // R6
    {3'b101, 32'h0000_0001},  // R7
    {3'b111, 32'h0002_0001},  // R7 both
    {3'b001, 32'h0000_0000}   // R6
  };

  task automatic burst(bit is_miss, int n);
    @(negedge clk);
    if (is_miss) m = 1'b1; else f = 1'b1;
    repeat (n) @(negedge clk);
    m = 1'b0; f = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'h0);

    for (int i = 0; i < 9; i++) begin
      {m, f, r} = VEC[i][34:32];
      @(negedge clk);
      chk($sformatf("R2/R3/R6/R7/R8 vector %0d", i), VEC[i][31:0]);
    end
    m = 0; f = 0; r = 0;

    burst(0, 2047);
    chk("R5 fifo at max", pack(0, 0, 2047, 0));
    burst(0, 1);
    chk("R5 fifo flag", pack(0, 0, 2047, 1));
    burst(0, 5);
    chk("R5 fifo held", pack(0, 0, 2047, 1));
    burst(1, 3);
    chk("R9 spare bits zero", pack(3, 0, 2047, 1));
    if (st[31:29] != 3'b000) chk("R9 spare", 32'h0);
    r = 1'b1;
    #1 chk("R6 value during read", pack(3, 0, 2047, 1));
    @(negedge clk); r = 1'b0;
    chk("R6 cleared", 32'h0);

    burst(1, 65535);
    chk("R4 miss at max", pack(65535, 0, 0, 0));
    burst(1, 2);
    chk("R4 miss flag", pack(65535, 1, 0, 0));
    @(negedge clk);
    chk("R4 flag sticky", pack(65535, 1, 0, 0));
    r = 1'b1; f = 1'b1;
    @(negedge clk); r = 1'b0; f = 1'b0;
    chk("R7 fifo event in read", pack(0, 0, 1, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(1_800_000ns);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule